// File: doc/BRIEF.md
# Byte-Lane Host Flag Register

This block keeps a 32-bit word of flags that a host and an execution engine share. The host can replace the whole word with one register write. It can also change any flag byte without disturbing the others: two write-only words carry a clear mask and a set mask for each byte, so one bus write updates a byte with no read-modify-write race. The engine side has its own strobe that ORs a mask into the flags.

Each flag byte has its own interrupt enable. The host changes these four enables only through a write-only control word, which has separate set and clear nibbles. The interrupt output is high while at least one enabled byte holds a nonzero value. The register port uses a single-cycle write strobe and a combinational read address. Bus protocol conversion is left to the surrounding logic.

Top module: `hostflag_bank`

## Requirements
- R1: After reset the flag word reads 0x00000000, every interrupt enable is clear, and `irq` is low.
- R2: A write to address 0 replaces the flag word with `wr_data`. A read of address 0 returns the new value in the cycle after the write edge.
- R3: A write to address 1 applies its masks to flag bytes 0 and 1: bits 7:0 clear byte 0, bits 15:8 set byte 0, bits 23:16 clear byte 1 and bits 31:24 set byte 1. A write to address 2 uses the same layout for bytes 2 and 3. Bytes that the word does not cover stay unchanged.
- R4: When a single set/clear write both sets and clears the same flag bit, the bit ends up set.
- R5: A write to address 3 sets the enable of byte n from bit 4+n and clears it from bit 12+n. If both bits are 1, the enable ends up set. All other bits of this word are ignored.
- R6: Reads of addresses 1, 2, 3 and of any unmapped address return zero. Writes to unmapped addresses (4 to 7) leave the flags and the enables unchanged.
- R7: `irq` equals the OR over n of (enable n AND the OR of the bits of flag byte n). It follows the register state in the same cycle that state changes.
- R8: When `eng_set` is high, `eng_mask` is ORred into the flags. It takes precedence over a host clear of the same bit in the same cycle.
- R9: When a direct write and an engine set happen in the same cycle, the flags become `wr_data | eng_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| eng_set | input | 1 | Engine-side set strobe |
| eng_mask | input | 32 | Bits the engine sets |
| irq | output | 1 | Interrupt request |

## Verification
A flag bit held in a wrong lane, or a set/clear priority that is inverted, shows up in the address-0 read in the cycle right after the offending write. The bench compares that read with its model on every clock. An enable that is wrong stays hidden until the matching byte holds a nonzero value, so the bench loads nonzero bytes before it toggles each enable. It then checks `irq` in the same cycle. A random phase mixes the engine strobe with host writes to expose any precedence fault within one cycle.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
   // word address of the directly writable flag word
   localparam int FLAG_OFS  = 0;
   // first set/clear word; the others follow, then the enable control word
   localparam int LANE_BASE = 1;
endpackage

// File: rtl/hfb_decode.sv
module hfb_decode #(
   parameter int DATA_W   = 32,
   parameter int LANE_W   = 8,
   parameter int N_LANES  = 4,
   parameter int ADDR_W   = 3,
   parameter int EN_SET_LSB = 4,
   parameter int EN_CLR_LSB = 12
) (
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   output logic                      dir_we,
   output logic [N_LANES*LANE_W-1:0] set_vec,
   output logic [N_LANES*LANE_W-1:0] clr_vec,
   output logic [N_LANES-1:0]        en_set,
   output logic [N_LANES-1:0]        en_clr
);
   import hfb_pkg::*;
   localparam int LPW      = DATA_W / (2*LANE_W);
   localparam int N_WORDS  = N_LANES / LPW;
   localparam int CTRL_OFS = LANE_BASE + N_WORDS;

   generate
      if (LPW < 1 || (N_LANES % LPW) != 0)
         $error("lane count must fill whole set/clear words");
      if (EN_CLR_LSB + N_LANES > DATA_W || EN_SET_LSB + N_LANES > EN_CLR_LSB)
         $error("enable control fields do not fit the data word");
      if (CTRL_OFS >= (1 << ADDR_W))
         $error("address width too small for the register map");
   endgenerate

   assign dir_we = wr_en && (wr_addr == ADDR_W'(FLAG_OFS));

   logic ctrl_hit;
   assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));
   assign en_set   = ctrl_hit ? wr_data[EN_SET_LSB +: N_LANES] : '0;
   assign en_clr   = ctrl_hit ? wr_data[EN_CLR_LSB +: N_LANES] : '0;

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(LANE_BASE + w));
      for (genvar s = 0; s < LPW; s++) begin : g_slot
         localparam int LN = w*LPW + s;
         assign clr_vec[LN*LANE_W +: LANE_W] =
            hit ? wr_data[s*2*LANE_W +: LANE_W] : '0;
         assign set_vec[LN*LANE_W +: LANE_W] =
            hit ? wr_data[s*2*LANE_W + LANE_W +: LANE_W] : '0;
      end
   end
endmodule

// File: rtl/hfb_flags.sv
module hfb_flags #(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 4,
   localparam int FW     = LANE_W * N_LANES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_we,
   input  logic [FW-1:0] dir_data,
   input  logic [FW-1:0] set_vec,
   input  logic [FW-1:0] clr_vec,
   input  logic          eng_set,
   input  logic [FW-1:0] eng_mask,
   output logic [FW-1:0] flags
);
   logic [FW-1:0] all_set;
   assign all_set = set_vec | (eng_set ? eng_mask : '0);

   for (genvar n = 0; n < N_LANES; n++) begin : g_lane
      logic [LANE_W-1:0] q, base, nxt;
      assign base = dir_we ? dir_data[n*LANE_W +: LANE_W] : q;
      assign nxt  = (base & ~clr_vec[n*LANE_W +: LANE_W])
                  | all_set[n*LANE_W +: LANE_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end
      assign flags[n*LANE_W +: LANE_W] = q;
   end

   // R4 R8: any requested set bit is present after the edge
   p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|all_set) |=> ((flags & $past(all_set)) == $past(all_set)));
   // R3: a clear without a competing set leaves the bit low
   p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |=> ((flags & $past(clr_vec & ~all_set)) == '0));
   // R6: nothing touching the flags keeps them stable
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_we && !(|all_set) && !(|clr_vec)) |=> $stable(flags));
   // R9: direct write content survives where no clear applies
   p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_we && !(|clr_vec)) |=> ((flags & $past(dir_data)) == $past(dir_data)));
endmodule

// File: rtl/hfb_irq.sv
module hfb_irq #(
   parameter int LANE_W  = 8,
   parameter int N_LANES = 4,
   parameter bit IRQ_REG = 1'b0,
   localparam int FW     = LANE_W * N_LANES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LANES-1:0] en_set,
   input  logic [N_LANES-1:0] en_clr,
   input  logic [FW-1:0]      flags,
   output logic [N_LANES-1:0] enables,
   output logic               irq
);
   logic [N_LANES-1:0] en_q, lane_hot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q & ~en_clr) | en_set;
   end
   assign enables = en_q;

   for (genvar n = 0; n < N_LANES; n++) begin : g_hot
      assign lane_hot[n] = en_q[n] & (|flags[n*LANE_W +: LANE_W]);
   end

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |lane_hot;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = |lane_hot;
      end
   endgenerate

   // R5: a requested enable set is present after the edge
   p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_set) |=> ((en_q & $past(en_set)) == $past(en_set)));
   // R5: a clear without a set drops the enable
   p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_clr) |=> ((en_q & $past(en_clr & ~en_set)) == '0));
endmodule

// File: rtl/hostflag_bank.sv
module hostflag_bank #(
   parameter int LANE_W     = 8,
   parameter int N_LANES    = 4,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 3,
   parameter int EN_SET_LSB = 4,
   parameter int EN_CLR_LSB = 12,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              eng_set,
   input  logic [DATA_W-1:0] eng_mask,
   output logic              irq
);
   import hfb_pkg::*;
   localparam int FW = LANE_W * N_LANES;

   generate
      if (FW != DATA_W) $error("flag word must match the data width");
   endgenerate

   logic               dir_we;
   logic [FW-1:0]      set_vec, clr_vec, flags;
   logic [N_LANES-1:0] en_set, en_clr, enables;

   hfb_decode #(.DATA_W(DATA_W), .LANE_W(LANE_W), .N_LANES(N_LANES),
                .ADDR_W(ADDR_W), .EN_SET_LSB(EN_SET_LSB),
                .EN_CLR_LSB(EN_CLR_LSB)) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dir_we(dir_we), .set_vec(set_vec), .clr_vec(clr_vec),
      .en_set(en_set), .en_clr(en_clr));

   hfb_flags #(.LANE_W(LANE_W), .N_LANES(N_LANES)) u_flags (
      .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .dir_data(wr_data),
      .set_vec(set_vec), .clr_vec(clr_vec), .eng_set(eng_set),
      .eng_mask(eng_mask), .flags(flags));

   hfb_irq #(.LANE_W(LANE_W), .N_LANES(N_LANES), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
      .flags(flags), .enables(enables), .irq(irq));

   assign rd_data = (rd_addr == ADDR_W'(FLAG_OFS)) ? flags : '0;

   // R7: an interrupt needs a nonzero flag in an enabled lane
   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((flags != '0) && (enables != '0)));
   // R1: state right after reset release is clear
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (flags == '0 && enables == '0));
endmodule

// File: tb/tb_hostflag_bank.sv
`timescale 1ns/100ps
module tb_hostflag_bank;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, eng_set = 1'b0;
   logic [2:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, eng_mask = '0, rd_data;
   logic        irq;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [31:0] m_flags = '0;
   logic [3:0]  m_en = '0;

   hostflag_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .eng_set(eng_set), .eng_mask(eng_mask), .irq(irq));

   always #2.5 clk = ~clk;

   function automatic logic m_irq();
      logic r = 1'b0;
      for (int n = 0; n < 4; n++)
         if (m_en[n] && m_flags[8*n +: 8] != 8'h00) r = 1'b1;
      return r;
   endfunction

   task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural model of one clock
   task automatic model_step();
      logic [31:0] f = m_flags;
      if (wr_en && wr_addr == 3'd0) f = wr_data;
      if (wr_en && (wr_addr == 3'd1 || wr_addr == 3'd2)) begin
         for (int half = 0; half < 2; half++) begin
            int byte_i = (wr_addr == 3'd1 ? 0 : 2) + half;
            logic [7:0] c = wr_data[16*half +: 8];
            logic [7:0] s = wr_data[16*half + 8 +: 8];
            f[8*byte_i +: 8] = (f[8*byte_i +: 8] & ~c) | s;
         end
      end
      if (eng_set) f = f | eng_mask;
      m_flags = f;
      if (wr_en && wr_addr == 3'd3) begin
         for (int n = 0; n < 4; n++) begin
            if (wr_data[12+n]) m_en[n] = 1'b0;
            if (wr_data[4+n])  m_en[n] = 1'b1;
         end
      end
   endtask

   // drive, clock, then compare flags readback and irq against the model
   task automatic cyc(string tag, logic we, logic [2:0] a, logic [31:0] d,
                      logic es, logic [31:0] em);
      wr_en = we; wr_addr = a; wr_data = d; eng_set = es; eng_mask = em;
      rd_addr = 3'd0;
      @(posedge clk);
      model_step();
      #1;
      wr_en = 1'b0; eng_set = 1'b0;
      check32({tag, " flags"}, rd_data, m_flags);
      check32({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq()});
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      @(negedge clk);
      check32("R1 reset flags", rd_data, 32'h0);
      check32("R1 reset irq", {31'd0, irq}, 32'd0);

      cyc("R2 direct write", 1, 3'd0, 32'hA5A5_0F0F, 0, 0);
      check32("R2 value", rd_data, 32'hA5A5_0F0F);
      cyc("R3 lanes 0/1", 1, 3'd1, {8'h01, 8'hFF, 8'h30, 8'h0F}, 0, 0);
      check32("R3 value", rd_data, 32'hA5A5_0130);
      cyc("R4 set wins", 1, 3'd2, {8'h00, 8'h00, 8'h81, 8'hFF}, 0, 0);
      check32("R4 value", rd_data, 32'hA581_0130);
      check32("R7 no enable no irq", {31'd0, irq}, 32'd0);
      cyc("R5 enable lane0", 1, 3'd3, 32'h0000_0010, 0, 0);
      check32("R7 irq lane0", {31'd0, irq}, 32'd1);
      cyc("R3 clear byte0", 1, 3'd1, 32'h0000_00FF, 0, 0);
      check32("R7 irq drops", {31'd0, irq}, 32'd0);
      cyc("R5 set/clear same enable", 1, 3'd3, 32'h0000_8080, 0, 0);
      check32("R5 set wins irq", {31'd0, irq}, 32'd1);
      cyc("R5 clear lane3", 1, 3'd3, 32'h0000_8000, 0, 0);
      check32("R5 cleared irq", {31'd0, irq}, 32'd0);
      cyc("R5 ignored bits", 1, 3'd3, 32'hFFFF_0F0F, 0, 0);
      check32("R5 ignored irq", {31'd0, irq}, 32'd0);
      cyc("R8 engine vs clear", 1, 3'd1, 32'h00FF_0000, 1, 32'h0000_0100);
      check32("R8 value", rd_data, 32'hA581_0100);
      cyc("R9 direct plus engine", 1, 3'd0, 32'h0000_0001, 1, 32'h1000_0000);
      check32("R9 value", rd_data, 32'h1000_0001);
      cyc("R6 unmapped write", 1, 3'd5, 32'hFFFF_FFFF, 0, 0);
      check32("R6 unmapped value", rd_data, 32'h1000_0001);
      cyc("R6 unmapped write 7", 1, 3'd7, 32'h0000_00F0, 0, 0);
      foreach (m_en[i]) ;
      for (int a = 1; a < 8; a++) begin
         rd_addr = 3'(a);
         #0.5;
         check32("R6 read zero", rd_data, 32'h0);
      end
      rd_addr = 3'd0;

      for (int i = 0; i < 400; i++) begin
         logic [2:0] a = 3'($urandom_range(0, 4));
         cyc("R7 random", $urandom_range(0, 1) == 1, a, $urandom,
             $urandom_range(0, 3) == 0, $urandom & $urandom & $urandom);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule